// File: doc/BRIEF.md
# Supervisory Reset and Watchdog Generator

This block drives the active-low system reset for a processor. Three causes can assert that reset. The first is power-up, which the synchronous reset input stands in for. The second is a low-supply indication from an external comparator. The third is a watchdog that the host must keep alive by producing serial-bus start conditions. A separate secondary-supply-good level passes straight through as an active-low fail output, so firmware can treat it as an early-warning interrupt.

A volatile flag tells firmware why the last reset happened. A supply dip clears the flag. A watchdog reset leaves it as it was. Firmware sets or clears it through a write port. When the supply drops, the block also sends a one-cycle abort pulse so the serial engine drops any command in progress.

All timing counts a 1 ms tick input. The parameter `TIME_DIV` divides every millisecond figure, rounding up, so that simulation runs short. With `TIME_DIV` = 50, the supply hold is 4 ticks and the watchdog hold is 3 ticks.

Top module: `sup_reset_gen`

## Requirements
- R1: While `rst` is high, `reset_n` is 0, `flag` is 0 and `abort_pulse` is 0. After `rst` falls with `vdd_ok` high, `reset_n` stays 0 until the ceil(200/TIME_DIV)-th tick has been sampled, and is 1 right after that edge.
- R2: A clock edge that samples `vdd_ok` = 0 drives `reset_n` to 0 right after that edge.
- R3: Ticks that arrive while `vdd_ok` is 0 do not count toward release. After `vdd_ok` returns to 1, `reset_n` is released on the edge that samples the ceil(200/TIME_DIV)-th tick.
- R4: A 1-to-0 change of `vdd_ok` produces `abort_pulse` = 1 for exactly one cycle. The pulse starts right after the edge that first samples `vdd_ok` low.
- R5: While `vdd_ok` is 0, `flag` is forced to 0, and a flag write in that time has no effect.
- R6: While `vdd_ok` is 1, an edge that samples `flag_we` = 1 loads `flag_wdata` into `flag`.
- R7: A watchdog reset leaves `flag` unchanged.
- R8: The `wd_sel` codes select these timeouts: 3'b000 = 1000 ms, 3'b001 = 450 ms, 3'b010 = 150 ms, 3'b100 = 60000 ms, 3'b101 = 20000 ms, 3'b110 = 10000 ms, 3'b111 = 5000 ms. Each timeout is ceil(ms/TIME_DIV) ticks. `reset_n` falls on the edge that samples the last of those ticks after the most recent restart.
- R9: Code 3'b011 disables the watchdog. Under that code, no number of ticks causes a reset.
- R10: A `start_det` pulse while `reset_n` = 1 restarts the watchdog count from zero.
- R11: A watchdog reset holds `reset_n` at 0 until the ceil(150/TIME_DIV)-th tick after the expiry, then releases it.
- R12: `start_det` pulses during reset neither change the hold nor carry over. The watchdog counts from zero once `reset_n` is released.
- R13: Any change of `wd_sel` restarts the watchdog count with the new period.
- R14: `v2fail_n` equals `v2_ok` combinationally, with no hold and no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, standing in for power-up |
| vdd_ok | input | 1 | Main supply good, from an external comparator |
| v2_ok | input | 1 | Secondary supply good |
| start_det | input | 1 | One-cycle pulse per detected bus start condition |
| tick_1ms | input | 1 | One-cycle timebase pulse, nominally every 1 ms |
| wd_sel | input | 3 | Watchdog period select code |
| flag_we | input | 1 | Flag write strobe from the control register |
| flag_wdata | input | 1 | Value written to the flag |
| reset_n | output | 1 | Active-low system reset |
| v2fail_n | output | 1 | Active-low secondary supply fail |
| flag | output | 1 | Volatile reset-cause flag |
| abort_pulse | output | 1 | One-cycle abort request to the serial engine |

## Verification
A wrong hold counter shows at `reset_n` as a release one tick early or late. That is visible on the edge of the expected release tick. A wrong watchdog count, a missed restart on a start pulse or a missed restart on a code change moves the falling edge of `reset_n` away from the predicted tick. It can also make that edge disappear. Flag corruption shows on `flag` one cycle after the supply dip, the write or the watchdog expiry. A broken edge detector shows as a missing or doubled `abort_pulse` on the cycle after the dip.

// File: rtl/sup_pkg.sv
package sup_pkg;

    typedef enum logic [2:0] {
        WD_1S    = 3'b000,
        WD_450MS = 3'b001,
        WD_150MS = 3'b010,
        WD_OFF   = 3'b011,
        WD_60S   = 3'b100,
        WD_20S   = 3'b101,
        WD_10S   = 3'b110,
        WD_5S    = 3'b111
    } wd_code_e;

    localparam int unsigned WD_MAX_MS = 60000;

    // nominal watchdog period in ms; 0 means disabled
    function automatic int unsigned wd_period_ms(input logic [2:0] code);
        case (wd_code_e'(code))
            WD_1S:    return 1000;
            WD_450MS: return 450;
            WD_150MS: return 150;
            WD_60S:   return 60000;
            WD_20S:   return 20000;
            WD_10S:   return 10000;
            WD_5S:    return 5000;
            default:  return 0;
        endcase
    endfunction

    // scaled tick count, rounded up, never below one
    function automatic int unsigned ms_to_ticks(input int unsigned ms, input int unsigned div);
        int unsigned t;
        t = (ms + div - 1) / div;
        return (t == 0) ? 1 : t;
    endfunction

endpackage

// File: rtl/sup_hold_timer.sv
module sup_hold_timer #(
    parameter int unsigned LV_TICKS = 200,
    parameter int unsigned WD_TICKS = 150,
    localparam int unsigned MAXT = (LV_TICKS > WD_TICKS) ? LV_TICKS : WD_TICKS,
    localparam int unsigned HW = $clog2(MAXT + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic vdd_ok,
    input  logic wd_fire,
    input  logic tick,
    output logic active
);
    logic [HW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !vdd_ok) begin
            active <= 1'b1;
            cnt_q  <= HW'(LV_TICKS);
        end else if (wd_fire) begin
            active <= 1'b1;
            cnt_q  <= HW'(WD_TICKS);
        end else if (active && tick) begin
            if (cnt_q <= HW'(1)) active <= 1'b0;
            else                 cnt_q  <= cnt_q - 1'b1;
        end
    end

    // R3: release happens only on a sampled tick
    p_release_on_tick_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(active) |-> $past(tick));

    // R2: a low supply always leaves the hold engaged
    p_low_holds_r2: assert property (@(posedge clk) disable iff (rst)
        !vdd_ok |=> active);

endmodule

// File: rtl/sup_wdog.sv
module sup_wdog
    import sup_pkg::*;
#(
    parameter int unsigned TIME_DIV = 1,
    localparam int unsigned MAX_TICKS = ms_to_ticks(WD_MAX_MS, TIME_DIV),
    localparam int unsigned CW = $clog2(MAX_TICKS + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       kick,
    input  logic       hold,
    input  logic [2:0] sel,
    output logic       expire
);
    logic [2:0]    sel_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last_cnt;
    logic          enabled;
    logic          changed;
    logic          restart;

    always_comb begin
        enabled  = (wd_code_e'(sel) != WD_OFF);
        changed  = (sel != sel_q);
        last_cnt = CW'(ms_to_ticks(wd_period_ms(sel), TIME_DIV) - 1);
        restart  = hold || kick || changed || !enabled;
        expire   = tick && !restart && (cnt_q == last_cnt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= sel;
            cnt_q <= '0;
        end else begin
            sel_q <= sel;
            if (restart)      cnt_q <= '0;
            else if (expire)  cnt_q <= '0;
            else if (tick)    cnt_q <= cnt_q + 1'b1;
        end
    end

    // R9: the disabled code never expires
    p_off_never_fires_r9: assert property (@(posedge clk) disable iff (rst)
        (wd_code_e'(sel) == WD_OFF) |-> !expire);

    // R12: count is empty on the cycle after any held cycle
    p_cleared_in_hold_r12: assert property (@(posedge clk) disable iff (rst)
        hold |=> (cnt_q == '0));

    // R10: a kick leaves the count at zero
    p_kick_clears_r10: assert property (@(posedge clk) disable iff (rst)
        kick |=> (cnt_q == '0));

endmodule

// File: rtl/sup_reset_gen.sv
module sup_reset_gen
    import sup_pkg::*;
#(
    parameter int unsigned TIME_DIV   = 1,
    parameter int unsigned LV_HOLD_MS = 200,
    parameter int unsigned WD_HOLD_MS = 150,
    localparam int unsigned LV_TICKS = ms_to_ticks(LV_HOLD_MS, TIME_DIV),
    localparam int unsigned WD_TICKS = ms_to_ticks(WD_HOLD_MS, TIME_DIV)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       vdd_ok,
    input  logic       v2_ok,
    input  logic       start_det,
    input  logic       tick_1ms,
    input  logic [2:0] wd_sel,
    input  logic       flag_we,
    input  logic       flag_wdata,
    output logic       reset_n,
    output logic       v2fail_n,
    output logic       flag,
    output logic       abort_pulse
);
    logic in_reset;
    logic wd_fire;
    logic vdd_prev_q;

    sup_hold_timer #(
        .LV_TICKS (LV_TICKS),
        .WD_TICKS (WD_TICKS)
    ) hold_i (
        .clk    (clk),
        .rst    (rst),
        .vdd_ok (vdd_ok),
        .wd_fire(wd_fire),
        .tick   (tick_1ms),
        .active (in_reset)
    );

    sup_wdog #(
        .TIME_DIV (TIME_DIV)
    ) wdog_i (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick_1ms),
        .kick   (start_det && !in_reset),
        .hold   (in_reset),
        .sel    (wd_sel),
        .expire (wd_fire)
    );

    assign reset_n  = !in_reset;
    assign v2fail_n = v2_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            vdd_prev_q  <= vdd_ok;
            abort_pulse <= 1'b0;
            flag        <= 1'b0;
        end else begin
            vdd_prev_q  <= vdd_ok;
            abort_pulse <= vdd_prev_q && !vdd_ok;
            if (!vdd_ok)      flag <= 1'b0;
            else if (flag_we) flag <= flag_wdata;
        end
    end

    p_low_supply_reset_r2: assert property (@(posedge clk) disable iff (rst)
        !vdd_ok |=> !reset_n);

    p_flag_cleared_r5: assert property (@(posedge clk) disable iff (rst)
        !vdd_ok |=> !flag);

    p_flag_write_r6: assert property (@(posedge clk) disable iff (rst)
        (vdd_ok && flag_we) |=> (flag == $past(flag_wdata)));

    p_abort_on_dip_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(vdd_ok) |=> abort_pulse);

    p_abort_single_r4: assert property (@(posedge clk) disable iff (rst)
        abort_pulse |=> !abort_pulse);

    p_wd_flag_kept_r7: assert property (@(posedge clk) disable iff (rst)
        (wd_fire && !flag_we && vdd_ok) |=> $stable(flag));

endmodule

// File: tb/sup_reset_gen_tb_top.sv
`timescale 1ns/1ps
module sup_reset_gen_tb_top;
    localparam int unsigned DIV = 50;
    localparam int LV_T = (200 + DIV - 1) / DIV;
    localparam int WD_T = (150 + DIV - 1) / DIV;

    typedef struct packed {
        logic [2:0]  code;
        logic [31:0] ms;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{3'b000, 32'd1000},  '{3'b001, 32'd450},   '{3'b010, 32'd150},
        '{3'b100, 32'd60000}, '{3'b101, 32'd20000}, '{3'b110, 32'd10000},
        '{3'b111, 32'd5000}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic vdd_ok = 1'b1;
    logic v2_ok = 1'b1;
    logic start_det = 1'b0;
    logic tick_1ms = 1'b0;
    logic [2:0] wd_sel = 3'b011;
    logic flag_we = 1'b0;
    logic flag_wdata = 1'b0;
    logic reset_n, v2fail_n, flag, abort_pulse;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    sup_reset_gen #(.TIME_DIV(DIV)) dut_i (
        .clk(clk), .rst(rst), .vdd_ok(vdd_ok), .v2_ok(v2_ok),
        .start_det(start_det), .tick_1ms(tick_1ms), .wd_sel(wd_sel),
        .flag_we(flag_we), .flag_wdata(flag_wdata),
        .reset_n(reset_n), .v2fail_n(v2fail_n), .flag(flag),
        .abort_pulse(abort_pulse)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_1ms = 1'b1; step();
            tick_1ms = 1'b0; step(); step(); step();
        end
    endtask

    task automatic kick();
        start_det = 1'b1; step();
        start_det = 1'b0;
    endtask

    task automatic write_flag(input logic v);
        flag_we = 1'b1; flag_wdata = v; step();
        flag_we = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not complete");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        step(); step();
        // R1 reset state
        check("R1", "reset_n in rst", reset_n, 1'b0);
        check("R1", "flag in rst", flag, 1'b0);
        check("R1", "abort in rst", abort_pulse, 1'b0);
        rst = 1'b0;
        step();
        ticks(LV_T - 1);
        check("R1", "power-up hold", reset_n, 1'b0);
        ticks(1);
        check("R1", "power-up release", reset_n, 1'b1);

        write_flag(1'b1);
        check("R6", "flag set", flag, 1'b1);

        // R8 / R11 / R7 table walk
        foreach (VECS[k]) begin
            int p;
            p = (int'(VECS[k].ms) + DIV - 1) / DIV;
            wd_sel = VECS[k].code;
            step();
            kick();
            ticks(p - 1);
            check("R8", "before expiry", reset_n, 1'b1);
            ticks(1);
            check("R8", "at expiry", reset_n, 1'b0);
            check("R7", "flag kept on wd reset", flag, 1'b1);
            ticks(WD_T - 1);
            check("R11", "wd hold", reset_n, 1'b0);
            ticks(1);
            check("R11", "wd release", reset_n, 1'b1);
        end

        // R9 disabled code
        wd_sel = 3'b011; step();
        ticks(1500);
        check("R9", "disabled no reset", reset_n, 1'b1);

        // R10 start restarts
        wd_sel = 3'b010; step();
        ticks(2);
        kick();
        ticks(2);
        check("R10", "kick postponed expiry", reset_n, 1'b1);
        ticks(1);
        check("R10", "expiry after kick", reset_n, 1'b0);
        ticks(WD_T);

        // R13 code change restarts
        wd_sel = 3'b000; step();
        ticks(15);
        wd_sel = 3'b001; step();
        ticks(8);
        check("R13", "new period not yet", reset_n, 1'b1);
        ticks(1);
        check("R13", "new period expiry", reset_n, 1'b0);

        // R12 kicks during hold ignored, count from zero at release
        kick();
        ticks(WD_T - 1);
        kick();
        check("R12", "hold unchanged by kicks", reset_n, 1'b0);
        ticks(1);
        check("R12", "release on time", reset_n, 1'b1);
        ticks(8);
        check("R12", "count from release", reset_n, 1'b1);
        ticks(1);
        check("R12", "expiry from release", reset_n, 1'b0);
        ticks(WD_T);
        wd_sel = 3'b011; step();

        // R2 / R4 / R5 supply dip
        check("R5", "flag before dip", flag, 1'b1);
        vdd_ok = 1'b0;
        step();
        check("R2", "reset on dip", reset_n, 1'b0);
        check("R4", "abort pulse", abort_pulse, 1'b1);
        check("R5", "flag cleared", flag, 1'b0);
        step();
        check("R4", "abort single", abort_pulse, 1'b0);
        write_flag(1'b1);
        check("R5", "write ignored while low", flag, 1'b0);
        ticks(10);
        check("R3", "no release while low", reset_n, 1'b0);
        vdd_ok = 1'b1;
        step();
        ticks(LV_T - 1);
        check("R3", "hold after return", reset_n, 1'b0);
        ticks(1);
        check("R3", "release after return", reset_n, 1'b1);
        check("R4", "no abort on rise", abort_pulse, 1'b0);

        // R6 write both values
        write_flag(1'b1);
        check("R6", "flag write 1", flag, 1'b1);
        write_flag(1'b0);
        check("R6", "flag write 0", flag, 1'b0);

        // R14 pass-through
        v2_ok = 1'b0; #1;
        check("R14", "v2fail low", v2fail_n, 1'b0);
        v2_ok = 1'b1; #1;
        check("R14", "v2fail high", v2fail_n, 1'b1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule